// File: doc/BRIEF.md
# Cascaded Three-Counter Interval Timer

This block holds three 16-bit down-counters behind a byte-wide host port with four addresses. Counters 0 and 1 are clocked by the block clock and always run as rate generators: each counts its preset down and reloads it, giving one terminal-count pulse per period. Counter 0's pulse is brought out as a plain rate output. Counter 1's pulse is the periodic tick interrupt.

Counter 2 never sees the clock directly. It steps once for every terminal count of counter 1. When it runs out it raises the interval interrupt. It then either stops (one-shot mode) or reloads and goes on (repeating mode). Control words that ask for anything beyond 16-bit binary loads in one of those two modes are refused, and the block flags the refusal. Two sticky status bits record tick and interval events until the host clears them.

Top module: `cascade_timer`

## Requirements
- R1: Address 0, 1 and 2 reach the data port of counter 0, 1 and 2. Address 3 is the control port. A read of address 3 returns 0xFF and has no effect on any counter or byte pointer.
- R2: A control word whose select field (bits 7:6) is 2'b11 raises `cfg_err` for exactly the cycle after the write.
- R3: A control word whose BCD bit (bit 0) is set, whose mode field (bits 3:1) is neither 3'b000 nor 3'b010, or whose access field (bits 5:4) is not 2'b11 also raises `cfg_err`, and it leaves that counter's stored mode unchanged. A legal word raises no error. It stores the mode, returns the counter's byte pointer to the low byte and stops or disarms that counter.
- R4: Each counter has one byte pointer, shared by data writes and reads, that toggles on every data access. When the pointer is low, a write sets the low byte of both preset and count. When it is high, the write sets the high byte.
- R5: A high-byte write to counter 0 or 1 starts it from the new value. It then produces a one-cycle pulse every P cycles, where P is the preset and a preset of 0 means 65536. Counter 0's pulse appears on `rate_out` and counter 1's on `tick_irq`. With the high byte written at clock edge E0, the first pulse is visible after edge E0+P.
- R6: `tick_sticky` is set together with every `tick_irq` pulse and holds until a `stat_clr` strobe with `stat_clr_bits[0]` set. If a tick and a clear happen in the same cycle, the set wins.
- R7: After counter 2's high byte is written, it decrements once per counter-1 terminal count. The step that takes it from 1 to its end raises `intvl_irq` in the same cycle as that `tick_irq` pulse, so for preset N the interval fires on the Nth tick.
- R8: In repeating mode (mode field 3'b010), counter 2 reloads its preset and fires again every N ticks. In one-shot mode (3'b000) it fires once and then stays at zero.
- R9: A data read returns the selected counter's current count, low byte when the pointer is low and high byte when it is high.
- R10: After reset every counter is stopped with count and preset zero, every pointer selects the low byte, counter 2 is in one-shot mode, and all outputs and status bits are 0.
- R11: `intvl_sticky` is set with every `intvl_irq` pulse and holds until a `stat_clr` strobe with `stat_clr_bits[1]` set. Bit 0 of the clear mask does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the count clock of counters 0 and 1 |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Host address: counter 0..2 data or control port |
| bus_wdata | input | 8 | Host write byte |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_rdata | output | 8 | Read byte, combinational while `bus_rd` is high |
| stat_clr | input | 1 | Status clear strobe |
| stat_clr_bits | input | 2 | Clear mask: bit 0 tick, bit 1 interval |
| rate_out | output | 1 | Counter 0 terminal-count pulse |
| tick_irq | output | 1 | Counter 1 terminal-count pulse |
| intvl_irq | output | 1 | Counter 2 expiry pulse |
| tick_sticky | output | 1 | Sticky tick status |
| intvl_sticky | output | 1 | Sticky interval status |
| cfg_err | output | 1 | One-cycle flag for a refused control word |

## Verification
A wrong count or a wrong reload shows on the pulse outputs as a shifted or missing pulse within one period. The bench therefore checks `tick_irq` and `intvl_irq` on every cycle of several periods over a sweep of small presets and both counter-2 modes. A mis-stepping byte pointer shows at once as swapped bytes on the next read. All 256 control words are written, and for each one the `cfg_err` flag must match a legality rule computed arithmetically in the bench. A mode change caused by an illegal word becomes visible only later, when counter 2 repeats or fails to repeat at its next expiry.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

  typedef struct packed {
    logic [1:0] sel;
    logic [1:0] access;
    logic [2:0] mode;
    logic       bcd;
  } ctrl_word_t;

  localparam logic [1:0] SEL_NONE     = 2'b11;
  localparam logic [1:0] ACC_LO_HI    = 2'b11;
  localparam logic [2:0] MODE_ONESHOT = 3'b000;
  localparam logic [2:0] MODE_RATE    = 3'b010;

  function automatic logic word_legal(ctrl_word_t w);
    logic mode_ok;
    mode_ok = (w.mode == MODE_ONESHOT) || (w.mode == MODE_RATE);
    return (w.sel != SEL_NONE) && (w.access == ACC_LO_HI) && !w.bcd && mode_ok;
  endfunction

endpackage

// File: rtl/ctmr_ctrl_decode.sv
module ctmr_ctrl_decode
  import ctmr_pkg::*;
(
  input  logic       ctrl_wr,
  input  logic [7:0] ctrl_byte,
  output logic [2:0] mode_ld,
  output logic [2:0] mode_val,
  output logic       ctrl_bad
);

  ctrl_word_t word;
  logic       legal;

  always_comb begin
    word     = ctrl_word_t'(ctrl_byte);
    legal    = word_legal(word);
    ctrl_bad = ctrl_wr && !legal;
    mode_val = word.mode;
    mode_ld  = 3'b000;
    if (ctrl_wr && legal) begin
      mode_ld[word.sel] = 1'b1;
    end
  end

endmodule

// File: rtl/ctmr_rate_counter.sv
module ctmr_rate_counter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wr_byte,
  output logic [DATA_W-1:0] rd_byte,
  output logic              term_cnt
);

  localparam int CNT_W = 2 * DATA_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] preset_q, count_q;
  logic             ptr_q, run_q;

  function automatic logic [CNT_W-1:0] next_count(logic [CNT_W-1:0] cur,
                                                  logic [CNT_W-1:0] pre,
                                                  logic at_end);
    return at_end ? pre : cur - ONE;
  endfunction

  assign term_cnt = run_q && (count_q == ONE) && !wr_en && !stop;
  assign rd_byte  = ptr_q ? count_q[CNT_W-1:DATA_W] : count_q[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset_q <= '0;
      count_q  <= '0;
      ptr_q    <= 1'b0;
      run_q    <= 1'b0;
    end else if (stop) begin
      ptr_q <= 1'b0;
      run_q <= 1'b0;
    end else if (wr_en) begin
      ptr_q <= ~ptr_q;
      if (!ptr_q) begin
        preset_q[DATA_W-1:0] <= wr_byte;
        count_q[DATA_W-1:0]  <= wr_byte;
      end else begin
        preset_q[CNT_W-1:DATA_W] <= wr_byte;
        count_q <= {wr_byte, count_q[DATA_W-1:0]};
        run_q   <= 1'b1;
      end
    end else begin
      if (rd_en) ptr_q <= ~ptr_q;
      if (run_q) count_q <= next_count(count_q, preset_q, term_cnt);
    end
  end

endmodule

// File: rtl/ctmr_interval_counter.sv
module ctmr_interval_counter
  import ctmr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ld,
  input  logic [2:0]        mode_val,
  input  logic              step,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wr_byte,
  output logic [DATA_W-1:0] rd_byte,
  output logic              expire
);

  localparam int CNT_W = 2 * DATA_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] preset_q, count_q;
  logic [2:0]       mode_q;
  logic             ptr_q, armed_q, repeat_mode;

  function automatic logic [CNT_W-1:0] after_step(logic [CNT_W-1:0] cur,
                                                  logic [CNT_W-1:0] pre,
                                                  logic at_end, logic again);
    if (!at_end) return cur - ONE;
    return again ? pre : '0;
  endfunction

  assign repeat_mode = (mode_q == MODE_RATE);
  assign expire  = armed_q && step && (count_q == ONE) && !wr_en && !mode_ld;
  assign rd_byte = ptr_q ? count_q[CNT_W-1:DATA_W] : count_q[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset_q <= '0;
      count_q  <= '0;
      mode_q   <= MODE_ONESHOT;
      ptr_q    <= 1'b0;
      armed_q  <= 1'b0;
    end else if (mode_ld) begin
      mode_q  <= mode_val;
      ptr_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (wr_en) begin
      ptr_q <= ~ptr_q;
      if (!ptr_q) begin
        preset_q[DATA_W-1:0] <= wr_byte;
        count_q[DATA_W-1:0]  <= wr_byte;
      end else begin
        preset_q[CNT_W-1:DATA_W] <= wr_byte;
        count_q <= {wr_byte, count_q[DATA_W-1:0]};
        armed_q <= 1'b1;
      end
    end else begin
      if (rd_en) ptr_q <= ~ptr_q;
      if (armed_q && step) begin
        count_q <= after_step(count_q, preset_q, expire, repeat_mode);
        if (expire) armed_q <= repeat_mode;
      end
    end
  end

endmodule

// File: rtl/cascade_timer.sv
module cascade_timer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              stat_clr,
  input  logic [1:0]        stat_clr_bits,
  output logic              rate_out,
  output logic              tick_irq,
  output logic              intvl_irq,
  output logic              tick_sticky,
  output logic              intvl_sticky,
  output logic              cfg_err
);

  localparam int N_RATE = 2;
  localparam int IV_IDX = N_RATE;
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic [2:0]        mode_ld;
  logic [2:0]        mode_val;
  logic              ctrl_bad;
  logic              ctrl_wr;
  logic [N_RATE-1:0] tc_rate;
  logic [DATA_W-1:0] rate_rd [N_RATE];
  logic [DATA_W-1:0] iv_rd;
  logic              iv_fire;
  logic              iv_wr, iv_rdsel;

  assign ctrl_wr  = bus_wr && (bus_addr == CTRL_ADDR);
  assign iv_wr    = bus_wr && (bus_addr == 2'(IV_IDX));
  assign iv_rdsel = bus_rd && !bus_wr && (bus_addr == 2'(IV_IDX));

  ctmr_ctrl_decode u_dec (
    .ctrl_wr  (ctrl_wr),
    .ctrl_byte(bus_wdata),
    .mode_ld  (mode_ld),
    .mode_val (mode_val),
    .ctrl_bad (ctrl_bad)
  );

  for (genvar gi = 0; gi < N_RATE; gi++) begin : g_rate
    logic sel_here;
    assign sel_here = (bus_addr == 2'(gi));
    ctmr_rate_counter #(.DATA_W(DATA_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .stop    (mode_ld[gi]),
      .wr_en   (bus_wr && sel_here),
      .rd_en   (bus_rd && !bus_wr && sel_here),
      .wr_byte (bus_wdata),
      .rd_byte (rate_rd[gi]),
      .term_cnt(tc_rate[gi])
    );
  end

  ctmr_interval_counter #(.DATA_W(DATA_W)) u_iv (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_ld (mode_ld[IV_IDX]),
    .mode_val(mode_val),
    .step    (tc_rate[1]),
    .wr_en   (iv_wr),
    .rd_en   (iv_rdsel),
    .wr_byte (bus_wdata),
    .rd_byte (iv_rd),
    .expire  (iv_fire)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        2'd0:    bus_rdata = rate_rd[0];
        2'd1:    bus_rdata = rate_rd[1];
        2'd2:    bus_rdata = iv_rd;
        default: bus_rdata = '1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_out     <= 1'b0;
      tick_irq     <= 1'b0;
      intvl_irq    <= 1'b0;
      tick_sticky  <= 1'b0;
      intvl_sticky <= 1'b0;
      cfg_err      <= 1'b0;
    end else begin
      rate_out     <= tc_rate[0];
      tick_irq     <= tc_rate[1];
      intvl_irq    <= iv_fire;
      cfg_err      <= ctrl_bad;
      tick_sticky  <= tc_rate[1] | (tick_sticky & ~(stat_clr & stat_clr_bits[0]));
      intvl_sticky <= iv_fire | (intvl_sticky & ~(stat_clr & stat_clr_bits[1]));
    end
  end

endmodule

// File: rtl/ctmr_checker.sv
module ctmr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_rdata,
  input logic       stat_clr,
  input logic [1:0] stat_clr_bits,
  input logic       tick_irq,
  input logic       intvl_irq,
  input logic       tick_sticky,
  input logic       intvl_sticky,
  input logic       cfg_err,
  input logic       tc1
);

  logic legal_word;
  always_comb begin
    legal_word = (bus_wdata[7:6] != 2'b11) && (bus_wdata[5:4] == 2'b11) &&
                 !bus_wdata[0] && ((bus_wdata[3:1] == 3'd0) || (bus_wdata[3:1] == 3'd2));
  end

  p_ctrl_read_ff_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == 2'd3) |-> (bus_rdata == 8'hFF));

  p_bad_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3 && bus_wdata[7:6] == 2'b11) |=> cfg_err);

  p_legal_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3 && legal_word) |=> !cfg_err);

  p_tick_follows_tc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tc1 |=> tick_irq);

  p_tick_sets_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |-> tick_sticky);

  p_tick_sticky_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_sticky && !(stat_clr && stat_clr_bits[0])) |=> tick_sticky);

  p_intvl_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    intvl_irq |-> tick_irq);

  p_intvl_sets_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    intvl_irq |-> intvl_sticky);

  p_intvl_sticky_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (intvl_sticky && !(stat_clr && stat_clr_bits[1])) |=> intvl_sticky);

endmodule

bind cascade_timer ctmr_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_rdata    (bus_rdata),
  .stat_clr     (stat_clr),
  .stat_clr_bits(stat_clr_bits),
  .tick_irq     (tick_irq),
  .intvl_irq    (intvl_irq),
  .tick_sticky  (tick_sticky),
  .intvl_sticky (intvl_sticky),
  .cfg_err      (cfg_err),
  .tc1          (tc_rate[1])
);

// File: tb/test_cascade_timer.sv
module test_cascade_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       stat_clr = 1'b0;
  logic [1:0] stat_clr_bits = '0;
  logic       rate_out, tick_irq, intvl_irq, tick_sticky, intvl_sticky, cfg_err;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cascade_timer i_cascade_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .stat_clr(stat_clr), .stat_clr_bits(stat_clr_bits),
    .rate_out(rate_out), .tick_irq(tick_irq), .intvl_irq(intvl_irq),
    .tick_sticky(tick_sticky), .intvl_sticky(intvl_sticky), .cfg_err(cfg_err)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic read_expect(input logic [1:0] a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    bus_read(a, v);
    chk(v == exp, req, v, exp);
  endtask

  task automatic clear_status(input logic [1:0] bits);
    stat_clr = 1'b1; stat_clr_bits = bits;
    @(negedge clk);
    stat_clr = 1'b0; stat_clr_bits = '0;
  endtask

  // Counter 2 cascade run: counter 1 period p, counter 2 preset n.
  task automatic run_interval(input int p, input int n, input bit rep, input bit prog_mode);
    bus_write(2'd3, 8'h74);                          // stop counter 1
    if (prog_mode) bus_write(2'd3, rep ? 8'hB4 : 8'hB0);
    bus_write(2'd2, 8'(n)); bus_write(2'd2, 8'h00);
    bus_write(2'd1, 8'(p)); bus_write(2'd1, 8'h00);
    for (int k = 1; k <= p * n * 3; k++) begin
      bit exp_t, exp_i;
      int tn;
      @(negedge clk);
      exp_t = (k % p) == 0;
      tn    = k / p;
      exp_i = exp_t && (rep ? ((tn % n) == 0) : (tn == n));
      chk(tick_irq == exp_t, "R5 tick period", tick_irq, exp_t);
      chk(intvl_irq == exp_i, rep ? "R8 repeat interval" : "R8/R7 one-shot interval",
          intvl_irq, exp_i);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk({rate_out, tick_irq, intvl_irq, tick_sticky, intvl_sticky, cfg_err} == 6'b0,
        "R10 outputs after reset", {rate_out, tick_irq, intvl_irq, tick_sticky, intvl_sticky, cfg_err}, 0);
    read_expect(2'd2, 8'h00, "R10 counter 2 low byte");
    read_expect(2'd2, 8'h00, "R10 counter 2 high byte");
    repeat (5) @(negedge clk);
    chk(rate_out == 1'b0 && tick_irq == 1'b0, "R10 counters stopped", {rate_out, tick_irq}, 0);

    // R4 / R9 / R1 byte pointer and reads
    bus_write(2'd2, 8'hC3); bus_write(2'd2, 8'hA5);
    read_expect(2'd3, 8'hFF, "R1 control read");
    read_expect(2'd2, 8'hC3, "R9 low byte first, R1 pointer untouched");
    read_expect(2'd2, 8'hA5, "R9 high byte second");
    read_expect(2'd2, 8'hC3, "R4 pointer toggles on read");
    bus_write(2'd3, 8'hB0);
    bus_write(2'd2, 8'h11);
    read_expect(2'd2, 8'hA5, "R4 pointer shared by write and read");
    read_expect(2'd2, 8'h11, "R4 low byte written");

    // R9 running counter read: count equals preset until the first edge after load
    bus_write(2'd0, 8'h34); bus_write(2'd0, 8'h12);
    read_expect(2'd0, 8'h34, "R9 running count low");
    read_expect(2'd0, 8'h12, "R9 running count high (0x1233)");

    // R2 / R3 exhaustive control word sweep
    for (int w = 0; w < 256; w++) begin
      int sel, acc, md;
      bit legal;
      sel = w / 64; acc = (w / 16) % 4; md = (w / 2) % 8;
      legal = (sel != 3) && (acc == 3) && ((w % 2) == 0) && (md == 0 || md == 2);
      bus_write(2'd3, 8'(w));
      chk(cfg_err == !legal, sel == 3 ? "R2 select 11" : "R3 control legality",
          cfg_err, !legal);
    end

    // R3 mode retained: last legal counter 2 word in the sweep was repeating mode
    run_interval(2, 2, 1'b1, 1'b0);

    // R5 period sweep on counter 1 with counter 2 disarmed
    bus_write(2'd3, 8'hB0);
    for (int p = 1; p <= 6; p++) begin
      bus_write(2'd3, 8'h74);
      bus_write(2'd1, 8'(p)); bus_write(2'd1, 8'h00);
      for (int k = 1; k <= 3 * p; k++) begin
        @(negedge clk);
        chk(tick_irq == ((k % p) == 0), "R5 tick period sweep", tick_irq, (k % p) == 0);
        chk(intvl_irq == 1'b0, "R7 disarmed counter 2 silent", intvl_irq, 0);
      end
    end

    // R7 / R8 cascade sweep
    for (int rep = 0; rep < 2; rep++)
      for (int n = 1; n <= 4; n++)
        for (int p = 1; p <= 3; p++)
          run_interval(p, n, rep[0], 1'b1);

    // R6 / R11 sticky clearing
    bus_write(2'd3, 8'h74);
    @(negedge clk);
    chk(tick_sticky == 1'b1 && intvl_sticky == 1'b1, "R6/R11 sticky set",
        {tick_sticky, intvl_sticky}, 2'b11);
    clear_status(2'b01);
    chk(tick_sticky == 1'b0, "R6 tick clear", tick_sticky, 0);
    chk(intvl_sticky == 1'b1, "R11 interval unaffected by bit 0", intvl_sticky, 1);
    clear_status(2'b10);
    chk(intvl_sticky == 1'b0, "R11 interval clear", intvl_sticky, 0);
    bus_write(2'd1, 8'h01); bus_write(2'd1, 8'h00);
    @(negedge clk);
    clear_status(2'b01);
    chk(tick_sticky == 1'b1, "R6 set wins over clear", tick_sticky, 1);
    bus_write(2'd3, 8'h74);

    // R5 counter 0 on rate_out, period 4 then preset 0 (65536)
    bus_write(2'd3, 8'h34);
    bus_write(2'd0, 8'h04); bus_write(2'd0, 8'h00);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      chk(rate_out == ((k % 4) == 0), "R5 rate_out period 4", rate_out, (k % 4) == 0);
    end
    bus_write(2'd3, 8'h34);
    bus_write(2'd0, 8'h00); bus_write(2'd0, 8'h00);
    begin
      int first;
      first = 0;
      for (int k = 1; k <= 65537; k++) begin
        @(negedge clk);
        if (rate_out && first == 0) first = k;
      end
      chk(first == 65536, "R5 zero preset means 65536", first, 65536);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule